// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register File

This block holds the host-visible control state of one bus-master DMA channel for a disk interface. Software programs a 32-bit descriptor-table base, chooses the transfer direction, sets a start flag once the drive command has gone out, and later reads a status byte to learn whether the transfer finished cleanly. The block passes start, direction and abort controls to a separate DMA engine. It takes back one-cycle completion and error events from that engine and raises an interrupt line.

The register window is 8 bytes, seen as two 32-bit words with per-byte enables. Word 0 holds the command byte in lane 0 and the status byte in lane 2. Lanes 1 and 3 are reserved. Word 1 holds the descriptor pointer. A read returns its data one cycle after the request. The status byte mixes three kinds of bit: a live activity flag that software cannot write, sticky error and interrupt flags that software clears by writing ones, and plain read/write per-drive capability flags.

Top module: `bmdma_regs`

## Requirements
- R1: After synchronous reset, all registers read 0, and `eng_go`, `eng_to_mem`, `eng_abort`, `irq` and `bus_rvalid` are 0.
- R2: Command bit 0 (word 0, lane 0) is the start flag. A write takes effect at the next clock edge and drives `eng_go` from that edge on.
- R3: Command bit 3 selects the direction (1 = drive to memory) and drives `eng_to_mem`. A write to bit 3 is ignored while the start flag is already 1.
- R4: Status bit 0 (active) becomes 1 when the start flag goes from 0 to 1. It becomes 0 when software writes the start flag to 0, or when an `eng_done` or `eng_error` event arrives.
- R5: Writing the start flag from 1 to 0 while the active bit is 1 gives a one-cycle `eng_abort` pulse. A stop written while the channel is not active gives no pulse.
- R6: An `eng_error` event sets status bit 1 and an `eng_done` event sets status bit 2. Each bit stays set until software clears it.
- R7: Writing 1 to status bit 1 or bit 2 (lane 2, data bits 17/18) clears that bit, and writing 0 leaves it unchanged. An engine event in the same cycle as the clearing write takes priority, so the bit stays set.
- R8: Status bits 5 and 6 (data bits 21/22) are plain read/write capability flags for drive 0 and drive 1.
- R9: `irq` is 1 exactly while status bit 2 is set.
- R10: Word 1 is the descriptor pointer, written per byte lane. Its low two bits always read 0.
- R11: A read returns data on `bus_rdata` with `bus_rvalid` high in the following cycle. Lanes 1 and 3 of word 0 read 0, and writes to them are ignored.
- R12: After a clean completion, status bits [2:0] read 100b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 0 = command/status word, 1 = descriptor pointer |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| eng_go | output | 1 | Start flag to the DMA engine |
| eng_to_mem | output | 1 | Direction to the engine, 1 = drive to memory |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_done | input | 1 | Engine completion event (one cycle) |
| eng_error | input | 1 | Engine error event (one cycle) |
| irq | output | 1 | Interrupt, mirrors status bit 2 |
| desc_ptr | output | 32 | Descriptor table base, dword aligned |

## Verification
Several properties are checked on every cycle. The active bit is never set while the start flag is clear. Direction holds steady while the channel runs. An engine event always leaves its sticky bit set on the next cycle. Abort is a lone pulse that arrives with the start flag already low. A full-word pointer write lands intact, and every read is answered one cycle later. Other behaviour shows up only in the bench scenarios: the exact status byte layout, the lane mapping, event-versus-clear priority in a shared cycle, the missing abort on an idle stop, and the 100b pattern after a clean run.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  // bit positions inside the command and status bytes; the driver decodes these
  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_DIR_BIT = 3;
  localparam int ST_ACT_BIT  = 0;
  localparam int ST_ERR_BIT  = 1;
  localparam int ST_INT_BIT  = 2;
  localparam int ST_CAP_BIT  = 5;
  // byte lanes inside word 0
  localparam int LANE_CMD  = 0;
  localparam int LANE_STAT = 2;

  typedef struct packed {
    logic go;
    logic to_mem;
  } cmd_t;
endpackage

// File: rtl/bmdma_cmd.sv
module bmdma_cmd
  import bmdma_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_go,
  input  logic wr_dir,
  input  logic active,
  output cmd_t cmd,
  output logic go_set,
  output logic go_clr,
  output logic abort
);
  cmd_t cmd_q;
  logic abort_q;

  assign go_set = wr_en && !cmd_q.go && wr_go;
  assign go_clr = wr_en && cmd_q.go && !wr_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= go_clr && active;
      if (wr_en) begin
        cmd_q.go <= wr_go;
        if (!cmd_q.go) cmd_q.to_mem <= wr_dir;
      end
    end
  end

  assign cmd   = cmd_q;
  assign abort = abort_q;

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q.go && $past(cmd_q.go)) |-> $stable(cmd_q.to_mem));

  // R5
  abort_single_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q);
endmodule

// File: rtl/bmdma_stat.sv
module bmdma_stat
  import bmdma_pkg::*;
#(
  parameter int NUM_DRV = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_clr_err,
  input  logic               wr_clr_int,
  input  logic [NUM_DRV-1:0] wr_cap,
  input  logic               go_set,
  input  logic               go_clr,
  input  logic               ev_done,
  input  logic               ev_err,
  output logic [7:0]         stat
);
  logic act_q, err_q, int_q;
  logic [NUM_DRV-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      if (go_clr)                 act_q <= 1'b0;
      else if (go_set)            act_q <= 1'b1;
      else if (ev_done || ev_err) act_q <= 1'b0;

      if (ev_err)                   err_q <= 1'b1;
      else if (wr_en && wr_clr_err) err_q <= 1'b0;

      if (ev_done)                  int_q <= 1'b1;
      else if (wr_en && wr_clr_int) int_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)        cap_q[i] <= 1'b0;
      else if (wr_en) cap_q[i] <= wr_cap[i];
    end
  end

  always_comb begin
    stat = '0;
    stat[ST_ACT_BIT] = act_q;
    stat[ST_ERR_BIT] = err_q;
    stat[ST_INT_BIT] = int_q;
    for (int i = 0; i < NUM_DRV; i++) stat[ST_CAP_BIT+i] = cap_q[i];
  end

  // R6
  done_sets_int_chk: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> stat[ST_INT_BIT]);
  // R6
  err_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> stat[ST_ERR_BIT]);
endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr #(
  parameter int PTR_W = 32,
  parameter int ALIGN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [PTR_W/8-1:0] be,
  input  logic [PTR_W-1:0]   wdata,
  output logic [PTR_W-1:0]   ptr
);
  localparam int LANES = PTR_W / 8;
  logic [PTR_W-1:0] ptr_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                ptr_q[l*8 +: 8] <= '0;
      else if (wr_en && be[l]) ptr_q[l*8 +: 8] <= wdata[l*8 +: 8];
    end
  end

  assign ptr = {ptr_q[PTR_W-1:ALIGN], {ALIGN{1'b0}}};

  // R10
  ptr_full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (&be)) |=> ptr[PTR_W-1:ALIGN] == $past(wdata[PTR_W-1:ALIGN]));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_DRV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              eng_go,
  output logic              eng_to_mem,
  output logic              eng_abort,
  input  logic              eng_done,
  input  logic              eng_error,
  output logic              irq,
  output logic [DATA_W-1:0] desc_ptr
);
  localparam int CMD_OFS  = LANE_CMD * 8;
  localparam int STAT_OFS = LANE_STAT * 8;

  logic w0_wr, cmd_wr, stat_wr, ptr_wr;
  logic go_set, go_clr;
  cmd_t cmd;
  logic [7:0] stat;
  logic [7:0] cmd_byte;
  logic [DATA_W-1:0] word0, rdata_q;
  logic rvalid_q;

  assign w0_wr   = bus_en && bus_we && !bus_word;
  assign cmd_wr  = w0_wr && bus_be[LANE_CMD];
  assign stat_wr = w0_wr && bus_be[LANE_STAT];
  assign ptr_wr  = bus_en && bus_we && bus_word;

  bmdma_cmd u_cmd (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cmd_wr),
    .wr_go  (bus_wdata[CMD_OFS+CMD_GO_BIT]),
    .wr_dir (bus_wdata[CMD_OFS+CMD_DIR_BIT]),
    .active (stat[ST_ACT_BIT]),
    .cmd    (cmd),
    .go_set (go_set),
    .go_clr (go_clr),
    .abort  (eng_abort)
  );

  bmdma_stat #(.NUM_DRV(NUM_DRV)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (stat_wr),
    .wr_clr_err (bus_wdata[STAT_OFS+ST_ERR_BIT]),
    .wr_clr_int (bus_wdata[STAT_OFS+ST_INT_BIT]),
    .wr_cap     (bus_wdata[STAT_OFS+ST_CAP_BIT +: NUM_DRV]),
    .go_set     (go_set),
    .go_clr     (go_clr),
    .ev_done    (eng_done),
    .ev_err     (eng_error),
    .stat       (stat)
  );

  bmdma_ptr #(.PTR_W(DATA_W), .ALIGN(2)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_en (ptr_wr),
    .be    (bus_be),
    .wdata (bus_wdata),
    .ptr   (desc_ptr)
  );

  always_comb begin
    cmd_byte = '0;
    cmd_byte[CMD_GO_BIT]  = cmd.go;
    cmd_byte[CMD_DIR_BIT] = cmd.to_mem;
    word0 = '0;
    word0[CMD_OFS +: 8]  = cmd_byte;
    word0[STAT_OFS +: 8] = stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_en && !bus_we;
      if (bus_en && !bus_we) rdata_q <= bus_word ? desc_ptr : word0;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign eng_go     = cmd.go;
  assign eng_to_mem = cmd.to_mem;
  assign irq        = stat[ST_INT_BIT];

  // R4
  act_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_go |-> !stat[ST_ACT_BIT]);
  // R5
  abort_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    eng_abort |-> !eng_go);
  // R11
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we) |=> bus_rvalid);
endmodule

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, eng_go, eng_to_mem, eng_abort, irq;
  logic eng_done = 1'b0, eng_error = 1'b0;
  logic [31:0] desc_ptr;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  bmdma_regs uut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_word(bus_word),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .eng_go(eng_go), .eng_to_mem(eng_to_mem),
    .eng_abort(eng_abort), .eng_done(eng_done), .eng_error(eng_error),
    .irq(irq), .desc_ptr(desc_ptr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data comes back
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) check("R11 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic word, input logic [3:0] be, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_word = word; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic word, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_word = word;
    @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_done();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic pulse_err();
    eng_error = 1'b1; @(negedge clk); eng_error = 1'b0;
  endtask

  initial begin
    #1_000_000;
    check("watchdog expired", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 eng_go", {31'b0, eng_go}, 0);
    check("R1 eng_to_mem", {31'b0, eng_to_mem}, 0);
    check("R1 eng_abort", {31'b0, eng_abort}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rvalid", {31'b0, bus_rvalid}, 0);
    rd(1'b0, 32'h0, "R1 word0");
    rd(1'b1, 32'h0, "R1 pointer");

    // R10 pointer, lane writes, alignment
    wr(1'b1, 4'hF, 32'h1234_5677);
    rd(1'b1, 32'h1234_5674, "R10 full write");
    wr(1'b1, 4'b0010, 32'h0000_AB00);
    rd(1'b1, 32'h1234_AB74, "R10 lane1 write");
    wr(1'b1, 4'b0001, 32'h0000_00FF);
    check("R10 desc_ptr aligned", desc_ptr, 32'h1234_ABFC);

    // R8 capability flags, R11 reserved lanes
    wr(1'b0, 4'b0100, 32'h0060_0000);
    rd(1'b0, 32'h0060_0000, "R8 cap flags");
    wr(1'b0, 4'b1010, 32'hFFFF_FFFF);
    rd(1'b0, 32'h0060_0000, "R11 reserved lanes");

    // R3 direction while stopped, R2/R4 start
    wr(1'b0, 4'b0001, 32'h0000_0008);
    check("R3 dir set while stopped", {31'b0, eng_to_mem}, 1);
    wr(1'b0, 4'b0001, 32'h0000_0009);
    check("R2 eng_go", {31'b0, eng_go}, 1);
    rd(1'b0, 32'h0061_0009, "R4 active after start");
    wr(1'b0, 4'b0001, 32'h0000_0001);
    check("R3 dir ignored while running", {31'b0, eng_to_mem}, 1);

    // R6/R9/R12 completion
    pulse_done();
    check("R9 irq after done", {31'b0, irq}, 1);
    rd(1'b0, 32'h0064_0009, "R12 success pattern 100b");
    wr(1'b0, 4'b0001, 32'h0000_0008);
    check("R5 no abort on idle stop", {31'b0, eng_abort}, 0);
    wr(1'b0, 4'b0100, 32'h0060_0000);
    rd(1'b0, 32'h0064_0008, "R7 write zero keeps int");
    wr(1'b0, 4'b0100, 32'h0066_0000);
    check("R9 irq cleared", {31'b0, irq}, 0);
    rd(1'b0, 32'h0060_0008, "R7 W1C int");

    // R5 abort while active
    wr(1'b0, 4'b0001, 32'h0000_0001);
    rd(1'b0, 32'h0061_0001, "R3 dir write while stopped");
    wr(1'b0, 4'b0001, 32'h0000_0000);
    check("R5 abort pulse", {31'b0, eng_abort}, 1);
    check("R2 eng_go cleared", {31'b0, eng_go}, 0);
    @(negedge clk);
    check("R5 abort one cycle", {31'b0, eng_abort}, 0);
    rd(1'b0, 32'h0060_0000, "R4 active cleared by stop");

    // R6 error event
    wr(1'b0, 4'b0001, 32'h0000_0001);
    pulse_err();
    check("R9 irq stays low on error", {31'b0, irq}, 0);
    rd(1'b0, 32'h0062_0001, "R6 error sticky");

    // R7 event beats clear in the same cycle
    bus_en = 1'b1; bus_we = 1'b1; bus_word = 1'b0; bus_be = 4'b0100;
    bus_wdata = 32'h0066_0000; eng_done = 1'b1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = '0; eng_done = 1'b0;
    check("R7 event wins over clear", {31'b0, irq}, 1);
    rd(1'b0, 32'h0064_0001, "R7 err cleared int kept");
    wr(1'b0, 4'b0100, 32'h0066_0000);
    rd(1'b0, 32'h0060_0001, "R7 final clear");

    repeat (3) @(negedge clk);
    check("R11 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule